// File: doc/BRIEF.md
# Delta-Sigma I/Q Carrier Transmitter

This block converts a stream of signed baseband I and Q samples into a single-bit serial stream. The stream stands for a modulated carrier whose frequency is an integer multiple N of the sample rate. There are no multipliers, no oscillator tables and no multi-bit converter. Each rail has its own second-order noise-shaping quantizer that reduces it to one bit per sample. The carrier is then formed only by selecting and inverting those bits in a fixed four-step rotation. Because the output never takes more than two levels, a switching power stage can take it directly and feed a band-pass reconstruction filter.

A fast clock drives the block, and the clock enable `en_i` gates it so that one output bit appears per enabled cycle. Four enabled cycles form one carrier period. N carrier periods form one baseband sample period, so the sample period is 4·N enabled cycles long. On the last enabled cycle of each sample period, both quantizers take a new input. A sample is used when `valid_i` is high at that cycle. When `valid_i` is low, each quantizer reuses the last sample it accepted.

Top module: `dsig_iq_tx`

## Requirements
- R1: The I quantizer and the Q quantizer keep separate state. The value on one rail has no effect on the bit density that the other rail produces.
- R2: In every quantizer bit and in `bit_o`, a 1 means +1 and a 0 means −1. For a steady input x (16-bit two's complement, full scale 2^15), the fraction of ones in a rail's bits tends to (1 + x/2^15)/2.
- R3: Inside each carrier period of four enabled cycles, the outputs are, in order: the I bit, the Q bit, the inverted I bit, and the inverted Q bit.
- R4: Each quantizer updates exactly once per 4·N enabled cycles, on the last cycle of a sample period. All N carrier periods within one sample period therefore carry identical bits.
- R5: While `en_i` is low, the phase, the carrier count, both quantizers and `bit_o` stay unchanged.
- R6: When `valid_i` is low at an update, the quantizer reuses its last accepted sample, and the current `i_i` and `q_i` are ignored.
- R7: Reset clears the quantizer state and both output bits to 0, and starts the rotation at the I phase. The first carrier period after reset is therefore 0,0,1,1.
- R8: With both inputs at zero, every window of 64 consecutive output bits contains exactly 32 ones.
- R9: The quantizer's internal sum saturates at ±4·2^15, so its error state stays within ±5·2^15. Inputs at either extreme give an all-zero rail (−32768) or an all-one rail (+32767).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Fast-clock enable; each enabled cycle produces one output bit |
| valid_i | input | 1 | Marks `i_i`/`q_i` as a new sample, taken at the sample boundary |
| i_i | input | 16 | In-phase sample, two's complement |
| q_i | input | 16 | Quadrature sample, two's complement |
| bit_o | output | 1 | Bi-level carrier stream, 1 = +1 |

## Verification
The bench drives several steady I/Q pairs and counts the ones at the I and Q phases over 256 sample periods.

- The zero pair exposes bias in the quantizer.
- Pairs with opposite signs or unequal magnitudes show whether the two rails are swapped or leak into each other.
- The two extreme values show saturation behaviour.

In every carrier period, the bench also checks that the third and fourth bits are the inverses of the first two. It checks that all carrier periods within one sample period match, which shows whether the rotation order or the update timing is wrong. Directed runs cover the following:

- the first bits after reset;
- a stall with `en_i` held low;
- a stretch with `valid_i` low while garbage sits on the data inputs;
- the 64-bit balance window at zero input.

// File: rtl/dsig_pkg.sv
package dsig_pkg;
  typedef enum logic [1:0] {
    PH_I  = 2'd0,
    PH_Q  = 2'd1,
    PH_NI = 2'd2,
    PH_NQ = 2'd3
  } phase_e;
endpackage

// File: rtl/dsig_phase_gen.sv
module dsig_phase_gen
  import dsig_pkg::*;
#(
  parameter int N = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  output phase_e ph_o,
  output logic   upd_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] CMAX = CW'(N - 1);

  phase_e        ph_q;
  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_I;
      cyc_q <= '0;
    end else if (en_i) begin
      ph_q <= phase_e'(ph_q + 2'd1);
      if (ph_q == PH_NQ) cyc_q <= (cyc_q == CMAX) ? '0 : cyc_q + 1'b1;
    end
  end

  assign ph_o  = ph_q;
  assign upd_o = en_i && (ph_q == PH_NQ) && (cyc_q == CMAX);

  // R3: rotation advances one step per enabled cycle
  a_r3_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (ph_q == phase_e'($past(ph_q) + 2'd1)));
  // R5: nothing moves while disabled
  a_r5_phase_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(ph_q) && $stable(cyc_q)));
  // R4: carrier count stays in range
  a_r4_cyc_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q <= CMAX);
endmodule

// File: rtl/dsig_dsm2.sv
module dsig_dsm2 #(
  parameter int DW = 16,
  parameter int SW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic          valid_i,
  input  logic [DW-1:0] x_i,
  output logic          y_o
);
  localparam int FS = 1 << (DW - 1);
  localparam logic signed [SW-1:0] FS_S  = SW'(FS);
  localparam logic signed [SW-1:0] LIM_S = SW'(4 * FS);
  localparam logic signed [SW-1:0] EB_S  = SW'(5 * FS);

  logic [DW-1:0]          held_q;
  logic [DW-1:0]          x_sel;
  logic signed [SW-1:0]   e1_q, e2_q;
  logic signed [SW-1:0]   xe, w_raw, w, e_new;
  logic                   y_q, y_new;

  always_comb begin
    x_sel = valid_i ? x_i : held_q;
    xe    = {{(SW-DW){x_sel[DW-1]}}, x_sel};
    // noise transfer (1 - z^-1)^2 via error feedback
    w_raw = xe - (e1_q <<< 1) + e2_q;
    if (w_raw > LIM_S)       w = LIM_S;
    else if (w_raw < -LIM_S) w = -LIM_S;
    else                     w = w_raw;
    y_new = (w >= 0);
    e_new = (y_new ? FS_S : -FS_S) - w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
      e1_q   <= '0;
      e2_q   <= '0;
      y_q    <= 1'b0;
    end else if (upd_i) begin
      held_q <= x_sel;
      e1_q   <= e_new;
      e2_q   <= e1_q;
      y_q    <= y_new;
    end
  end

  assign y_o = y_q;

  // R9: error state bounded by saturation
  a_r9_err_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e1_q <= EB_S) && (e1_q >= -EB_S));
  // R4: output bit changes only at an update
  a_r4_upd_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(y_q));
  // R6: held sample kept when no valid at the boundary
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !valid_i) |=> $stable(held_q));
endmodule

// File: rtl/dsig_interleave.sv
module dsig_interleave
  import dsig_pkg::*;
(
  input  phase_e ph_i,
  input  logic   yi_i,
  input  logic   yq_i,
  output logic   bit_o
);
  always_comb begin
    unique case (ph_i)
      PH_I:    bit_o = yi_i;
      PH_Q:    bit_o = yq_i;
      PH_NI:   bit_o = ~yi_i;
      default: bit_o = ~yq_i;
    endcase
  end
endmodule

// File: rtl/dsig_iq_tx.sv
module dsig_iq_tx
  import dsig_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 16,
  parameter int SW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          valid_i,
  input  logic [DW-1:0] i_i,
  input  logic [DW-1:0] q_i,
  output logic          bit_o
);
  localparam int RAILS = 2;

  phase_e          ph;
  logic            upd;
  logic [DW-1:0]   x_rail [RAILS];
  logic [RAILS-1:0] y_rail;

  assign x_rail[0] = i_i;
  assign x_rail[1] = q_i;

  dsig_phase_gen #(.N(N)) u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .ph_o  (ph),
    .upd_o (upd)
  );

  for (genvar r = 0; r < RAILS; r++) begin : g_rail
    dsig_dsm2 #(.DW(DW), .SW(SW)) u_dsm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .upd_i  (upd),
      .valid_i(valid_i),
      .x_i    (x_rail[r]),
      .y_o    (y_rail[r])
    );
  end

  dsig_interleave u_mux (
    .ph_i (ph),
    .yi_i (y_rail[0]),
    .yq_i (y_rail[1]),
    .bit_o(bit_o)
  );

  // R5: output frozen while disabled
  a_r5_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(bit_o));
  // R3: inverted I phase follows Q phase
  a_r3_inv_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ph == PH_Q) |=> (bit_o == !y_rail[0]));
endmodule

// File: tb/tb_dsig_iq_tx.sv
`timescale 1ns/1ps
module tb_dsig_iq_tx;
  localparam int N      = 4;
  localparam int K      = 256;
  localparam int SETTLE = 16;
  localparam int TOL    = 10;
  localparam int NV     = 7;
  // i, q, expected ones at I phase, expected ones at Q phase (per K samples)
  localparam int VEC [NV][4] = '{
    '{      0,      0, 128, 128},
    '{  16384, -16384, 192,  64},
    '{  -8192,   8192,  96, 160},
    '{  16384,  16384, 192, 192},
    '{ -16384,   4096,  64, 144},
    '{ -32768,      0,   0, 128},
    '{  32767, -32768, 256,   0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] i_i = '0;
  logic [15:0] q_i = '0;
  logic        bit_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dsig_iq_tx #(.N(N)) dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .valid_i(valid_i),
    .i_i    (i_i),
    .q_i    (q_i),
    .bit_o  (bit_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // read current bit, then advance one enabled cycle
  task automatic step(output logic b);
    b = bit_o;
    @(negedge clk);
  endtask

  // one sample period; returns I and Q bits, flags rotation/repeat errors
  task automatic sample(output logic bi, output logic bq, inout int bad3, inout int bad4,
                        inout logic [63:0] hist, inout int nbits, inout int bad8, input bit zchk);
    logic b [4];
    for (int c = 0; c < N; c++) begin
      for (int p = 0; p < 4; p++) begin
        step(b[p]);
        hist = {hist[62:0], b[p]};
        nbits++;
        if (zchk && nbits >= 64 && $countones(hist) != 32) bad8++;
      end
      if (b[2] != !b[0] || b[3] != !b[1]) bad3++;
      if (c == 0) begin
        bi = b[0];
        bq = b[1];
      end else if (b[0] != bi || b[1] != bq) bad4++;
    end
  endtask

  task automatic run_dc(input int ei, input int eq, input string tag, input bit zchk);
    logic bi, bq;
    int ci = 0, cq = 0, bad3 = 0, bad4 = 0, bad8 = 0, nbits = 0;
    logic [63:0] hist = '0;
    for (int s = 0; s < SETTLE; s++) sample(bi, bq, bad3, bad4, hist, nbits, bad8, 1'b0);
    nbits = 0;
    for (int s = 0; s < K; s++) begin
      sample(bi, bq, bad3, bad4, hist, nbits, bad8, zchk);
      ci += int'(bi);
      cq += int'(bq);
    end
    chk((ci >= ei - TOL) && (ci <= ei + TOL), {"R2 I density ", tag}, ci, ei);
    chk((cq >= eq - TOL) && (cq <= eq + TOL), {"R1 Q density ", tag}, cq, eq);
    chk(bad3 == 0, {"R3 rotation ", tag}, bad3, 0);
    chk(bad4 == 0, {"R4 repeat ", tag}, bad4, 0);
    if (zchk) chk(bad8 == 0, "R8 64-bit balance", bad8, 0);
  endtask

  initial begin
    #(5ns * 180000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic b0, b1, b2, b3, bs;
    repeat (3) @(negedge clk);
    chk(bit_o == 1'b0, "R7 reset bit", int'(bit_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(bit_o == 1'b0, "R7 idle after reset", int'(bit_o), 0);
    en_i = 1'b1;
    step(b0); step(b1); step(b2); step(b3);
    chk({b0, b1, b2, b3} == 4'b0011, "R7 first period", int'({b0, b1, b2, b3}), 3);
    // finish first sample period (phase aligned again)
    for (int t = 4; t < 4 * N; t++) step(b0);

    // table walk
    valid_i = 1'b1;
    for (int v = 0; v < NV; v++) begin
      i_i = 16'(VEC[v][0]);
      q_i = 16'(VEC[v][1]);
      run_dc(VEC[v][2], VEC[v][3], $sformatf("vec%0d", v), v == 0);
    end

    // R5: stall mid period (after one step: Q phase)
    step(b0);
    en_i = 1'b0;
    bs = bit_o;
    repeat (6) begin
      @(negedge clk);
      if (bit_o != bs) b1 = 1'b1;
    end
    chk(bit_o == bs, "R5 stall hold", int'(bit_o), int'(bs));
    en_i = 1'b1;
    for (int t = 1; t < 4 * N; t++) step(b0);

    // R6: load a sample, then drop valid with garbage on the data
    i_i = 16'(16384);
    q_i = 16'(-16384);
    run_dc(192, 64, "load", 1'b0);
    valid_i = 1'b0;
    i_i = 16'(-32768);
    q_i = 16'(32767);
    run_dc(192, 64, "R6 hold", 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule